// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block carries 36-bit words one way, from a writer on clock A to a reader on clock B. The two clocks may be unrelated or may be the same clock. Each port does a transfer on a rising edge of its own clock only when three things hold together: its select is low, its enable is high and its direction input is high. The reader sees a registered output word, and a ready flag says the word is valid. The writer has its own ready flag, which tells it when space is free. Two active-low programmable flags compare the fill level against offset values that arrive as inputs.

A retransmit mode lets the reader mark the word it currently holds and later rewind to it. While the mode is on, the write side counts the marked word as still occupied, so no write can overwrite data that may be read again. Pointers cross between the two domains as Gray codes through two-flop synchronizers.

The read side runs two small state machines. The output machine has two states. It goes from `RD_EMPTY` to `RD_VALID` when it loads a word, either a fetch or a rewind. It goes from `RD_VALID` to `RD_EMPTY` when a read consumes the last fetched word and nothing is left to fetch. It stays in `RD_VALID` while reads are matched by fetches. The retransmit machine goes from `RT_OFF` to `RT_ON` when the mode request is high while the output word is valid, and records the mark at that edge. It goes from `RT_ON` back to `RT_OFF` on any clock-B edge with the mode request low.

Top module: `dcf_retx_fifo`

## Requirements
- R1: A word is stored on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1 and `a_ready`=1. Any other combination leaves the stored contents unchanged.
- R2: A read happens on a rising `clk_b` edge only when `b_cs_n`=0, `b_rd`=1, `b_en`=1 and `b_ready`=1. A read replaces `b_data` with the next stored word. Otherwise `b_data` holds.
- R3: `a_ready` is low while 2^AW words are held, counting the word in the output register. Writes attempted then are dropped.
- R4: `b_ready` is low when no unread word is held. Reads attempted then have no effect.
- R5: After a word is written into an empty FIFO, `b_ready` rises on the third rising `clk_b` edge after the write edge.
- R6: Words leave the FIFO in the order they were accepted, and none is lost or repeated outside a rewind.
- R7: Once the flags have settled, `b_almost_empty_n` is low exactly when the unread word count is at most `ofs_empty`.
- R8: Once the flags have settled, `a_almost_full_n` is low exactly when the free location count is at most `ofs_full`. In retransmit mode, the free count is measured from the marked word.
- R9: While `rst_n` is low, `a_ready`=0, `b_ready`=0, `b_almost_empty_n`=0 and `a_almost_full_n`=1. `a_ready` rises on the first `clk_a` edge after release. Reset must be held for at least four edges of each clock.
- R10: A rising `clk_b` edge with `rt_mode_req`=1 and `b_ready`=1 while the mode is off makes the current output word the mark and turns the mode on. The mode turns off on a rising `clk_b` edge with `rt_mode_req`=0.
- R11: In retransmit mode, an edge with `rt_mode_req`=1 and `rt_rewind`=1 puts the marked word on `b_data` with `b_ready`=1, and later reads continue from the word after the mark. `rt_rewind` has no effect while the mode is off.
- R12: In retransmit mode, `a_ready` falls once 2^AW words from the mark onward are held, so marked data is never overwritten. Space is released again after the mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| a_cs_n | input | 1 | Write port select, active low |
| a_wr | input | 1 | Write port direction, 1 = write |
| a_en | input | 1 | Write port enable |
| a_data | input | DW | Word to store |
| a_ready | output | 1 | Space available, clock A |
| a_almost_full_n | output | 1 | Low when free space is at most `ofs_full` |
| ofs_full | input | AW+1 | Almost-full offset |
| b_cs_n | input | 1 | Read port select, active low |
| b_rd | input | 1 | Read port direction, 1 = read |
| b_en | input | 1 | Read port enable |
| b_data | output | DW | Registered output word |
| b_ready | output | 1 | Output word valid, clock B |
| b_almost_empty_n | output | 1 | Low when the unread count is at most `ofs_empty` |
| ofs_empty | input | AW+1 | Almost-empty offset |
| rt_mode_req | input | 1 | Retransmit mode request |
| rt_rewind | input | 1 | Rewind to the mark |

## Verification
The assertions assume that the port controls and retransmit inputs are steady around each rising edge of their own clock. They also assume that reset is held low over several edges of both clocks, so no pointer is caught mid-update. They further assume that `rt_rewind` is only meaningful while `rt_mode_req` stays high. The stimulus changes every input on the falling edge, clocks both ports from one 200 MHz source, and keeps reset low for several edges before releasing it between edges. Flag checks wait for the synchronizers and the space pointer to settle before comparing with the model.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    typedef enum logic {RD_EMPTY, RD_VALID} rd_state_t;
    typedef enum logic {RT_OFF, RT_ON} rt_state_t;
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_in;
            s2_q <= s1_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign bin_out[i] = ^s2_q[W-1:i];
        end
    endgenerate
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          dir,
    input  logic          en,
    input  logic [AW:0]   keep_s,
    input  logic [AW:0]   ofs_y,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          ready,
    output logic          af_n
);
    localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

    logic [AW:0] wbin_q, wbin_d, lvl_q, lvl_d;

    always_comb begin
        we     = !cs_n && dir && en && ready;
        wbin_d = wbin_q + {{AW{1'b0}}, we};
        lvl_q  = wbin_q - keep_s;
        lvl_d  = wbin_d - keep_s;
    end

    assign waddr = wbin_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q <= '0;
            wgray  <= '0;
            ready  <= 1'b0;
            af_n   <= 1'b1;
        end else begin
            wbin_q <= wbin_d;
            wgray  <= wbin_d ^ (wbin_d >> 1);
            ready  <= (lvl_d != FULL);
            af_n   <= ((FULL - lvl_d) > ofs_y);
        end
    end

    // R3 / R12: the protected span never exceeds capacity
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= FULL);
    // R3 / R12: a full span always shows as not ready
    assert_full_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == FULL) |-> !ready);
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          dir,
    input  logic          en,
    input  logic          rtm,
    input  logic          rfm,
    input  logic [AW:0]   wbin_s,
    input  logic [AW:0]   ofs_x,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   keep_gray,
    output logic [DW-1:0] dout,
    output logic          ordy,
    output logic          ae_n
);
    localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

    rd_state_t or_q, or_d;
    rt_state_t rt_q, rt_d;
    logic [AW:0] rbin_q, rbin_d, mark_q, mark_d, keep_q, keep_d;
    logic [AW:0] head, head_d, target;
    logic [DW-1:0] dout_d;
    logic ae_n_d, rd_fire, rewind, avail, fetch, load;

    always_comb begin
        rd_fire = !cs_n && dir && en && (or_q == RD_VALID);
        rewind  = (rt_q == RT_ON) && rtm && rfm;
        avail   = (rbin_q != wbin_s);
        fetch   = !rewind && avail && ((or_q == RD_EMPTY) || rd_fire);
        load    = rewind || fetch;
        head    = rbin_q - {{AW{1'b0}}, (or_q == RD_VALID)};
    end

    // Next-state logic for both machines
    always_comb begin
        or_d = or_q;
        unique case (or_q)
            RD_EMPTY: if (load) or_d = RD_VALID;
            RD_VALID: if (!load && rd_fire) or_d = RD_EMPTY;
        endcase
        rt_d   = rt_q;
        mark_d = mark_q;
        unique case (rt_q)
            RT_OFF: if (rtm && (or_q == RD_VALID)) begin
                rt_d   = RT_ON;
                mark_d = head;
            end
            RT_ON: if (!rtm) rt_d = RT_OFF;
        endcase
    end

    // Datapath and flag outputs
    always_comb begin
        rbin_d    = rbin_q;
        dout_d    = dout;
        mem_raddr = rbin_q[AW-1:0];
        if (rewind) begin
            mem_raddr = mark_q[AW-1:0];
            rbin_d    = mark_q + ONE;
        end else if (fetch) begin
            rbin_d = rbin_q + ONE;
        end
        if (load) dout_d = mem_rdata;
        head_d = rbin_d - {{AW{1'b0}}, (or_d == RD_VALID)};
        target = (rt_q == RT_ON) ? mark_q : head;
        keep_d = (keep_q != target) ? keep_q + ONE : keep_q;
        ae_n_d = ((wbin_s - head_d) > ofs_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            or_q      <= RD_EMPTY;
            rt_q      <= RT_OFF;
            rbin_q    <= '0;
            mark_q    <= '0;
            keep_q    <= '0;
            keep_gray <= '0;
            dout      <= '0;
            ae_n      <= 1'b0;
        end else begin
            or_q      <= or_d;
            rt_q      <= rt_d;
            rbin_q    <= rbin_d;
            mark_q    <= mark_d;
            keep_q    <= keep_d;
            keep_gray <= keep_d ^ (keep_d >> 1);
            dout      <= dout_d;
            ae_n      <= ae_n_d;
        end
    end

    assign ordy = (or_q == RD_VALID);

    // R2: an unread valid word stays put
    assert_hold_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((or_q == RD_VALID) && !rd_fire && !rewind) |=> ((or_q == RD_VALID) && $stable(dout)));
    // R4: with nothing to fetch and the output empty, the read pointer holds
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((or_q == RD_EMPTY) && !avail && !rewind) |=> $stable(rbin_q));
    // R10: entry records the head word as the mark
    assert_mark_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rt_q == RT_OFF) && rtm && (or_q == RD_VALID)) |=> ((rt_q == RT_ON) && (mark_q == $past(head))));
    // R11: a rewind leaves a valid word and the fetch pointer just past the mark
    assert_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> ((or_q == RD_VALID) && (rbin_q == $past(mark_q) + ONE)));
endmodule

// File: rtl/dcf_retx_fifo.sv
`timescale 1ns/1ps
module dcf_retx_fifo #(
    parameter int AW = 9,
    parameter int DW = 36
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          a_cs_n,
    input  logic          a_wr,
    input  logic          a_en,
    input  logic [DW-1:0] a_data,
    output logic          a_ready,
    output logic          a_almost_full_n,
    input  logic [AW:0]   ofs_full,
    input  logic          b_cs_n,
    input  logic          b_rd,
    input  logic          b_en,
    output logic [DW-1:0] b_data,
    output logic          b_ready,
    output logic          b_almost_empty_n,
    input  logic [AW:0]   ofs_empty,
    input  logic          rt_mode_req,
    input  logic          rt_rewind
);
    logic [AW:0]   wgray, wbin_s, kgray, keep_s;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata;

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .clk(clk_a), .rst_n(rst_n), .cs_n(a_cs_n), .dir(a_wr), .en(a_en),
        .keep_s(keep_s), .ofs_y(ofs_full), .we(we), .waddr(waddr),
        .wgray(wgray), .ready(a_ready), .af_n(a_almost_full_n)
    );

    dcf_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk_a), .we(we), .waddr(waddr), .wdata(a_data),
        .raddr(raddr), .rdata(rdata)
    );

    dcf_ptr_sync #(.W(AW+1)) u_w2r (
        .clk(clk_b), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    dcf_ptr_sync #(.W(AW+1)) u_r2w (
        .clk(clk_a), .rst_n(rst_n), .gray_in(kgray), .bin_out(keep_s)
    );

    dcf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk_b), .rst_n(rst_n), .cs_n(b_cs_n), .dir(b_rd), .en(b_en),
        .rtm(rt_mode_req), .rfm(rt_rewind), .wbin_s(wbin_s), .ofs_x(ofs_empty),
        .mem_rdata(rdata), .mem_raddr(raddr), .keep_gray(kgray),
        .dout(b_data), .ordy(b_ready), .ae_n(b_almost_empty_n)
    );
endmodule

// File: tb/test_dcf_retx_fifo.sv
`timescale 1ns/1ps
module test_dcf_retx_fifo;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DW = 36;
    localparam int XOFS = 2;
    localparam int YOFS = 3;
    localparam logic [2:0] P_GO = 3'b011;  // {cs_n, dir, en}
    localparam logic [2:0] P_OFF = 3'b100;
    localparam logic [2:0] P_NOEN = 3'b010;
    localparam logic [2:0] P_DIR0 = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0;
    logic [DW-1:0] a_data = '0;
    logic b_cs_n = 1'b1, b_rd = 1'b0, b_en = 1'b0;
    logic rt_mode_req = 1'b0, rt_rewind = 1'b0;
    logic a_ready, a_almost_full_n, b_ready, b_almost_empty_n;
    logic [DW-1:0] b_data;

    dcf_retx_fifo #(.AW(AW), .DW(DW)) i_dcf_retx_fifo (
        .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_data(a_data),
        .a_ready(a_ready), .a_almost_full_n(a_almost_full_n),
        .ofs_full(5'(YOFS)),
        .b_cs_n(b_cs_n), .b_rd(b_rd), .b_en(b_en), .b_data(b_data),
        .b_ready(b_ready), .b_almost_empty_n(b_almost_empty_n),
        .ofs_empty(5'(XOFS)),
        .rt_mode_req(rt_mode_req), .rt_rewind(rt_rewind)
    );

    logic [DW-1:0] written[$];
    int rd_idx = 0, mark_idx = 0, seq = 0, checks = 0, fails = 0;
    bit m_rt = 0, hold_rtm = 0, done = 0;

    function automatic logic [DW-1:0] mkd(input int n);
        return {4'(n + 5), 32'(n * 32'h9E37_79B9)};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model, check at next falling edge
    task automatic step(input logic [2:0] actl, input logic [DW-1:0] d,
                        input logic [2:0] bctl, input bit rtm, input bit rfm);
        bit pre_ir, pre_or, rw;
        int old;
        {a_cs_n, a_wr, a_en} = actl;
        a_data = d;
        {b_cs_n, b_rd, b_en} = bctl;
        rt_mode_req = rtm;
        rt_rewind = rfm;
        pre_ir = a_ready;
        pre_or = b_ready;
        @(posedge clk);
        @(negedge clk);
        if (actl == P_GO && pre_ir) written.push_back(d);
        old = rd_idx;
        rw = m_rt && rtm && rfm;
        if (rw) rd_idx = mark_idx;
        else if (bctl == P_GO && pre_or) rd_idx++;
        if (!m_rt && rtm && pre_or) begin
            m_rt = 1;
            mark_idx = old;
        end else if (m_rt && !rtm) m_rt = 0;
        if (b_ready) begin
            if (rd_idx < written.size())
                chk(b_data == written[rd_idx], "R6 output word order", b_data, written[rd_idx]);
            else
                chk(0, "R4 ready with nothing stored", 1, 0);
        end
        if (rw) chk(b_ready, "R11 rewind leaves word valid", b_ready, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) step(P_OFF, '0, P_OFF, hold_rtm, 0);
    endtask

    task automatic wr1();
        step(P_GO, mkd(seq), P_OFF, hold_rtm, 0);
        seq++;
    endtask

    task automatic rd1();
        step(P_OFF, '0, P_GO, hold_rtm, 0);
    endtask

    task automatic settle_check();
        int stored, prot;
        idle(30);
        stored = written.size() - rd_idx;
        prot = written.size() - (m_rt ? mark_idx : rd_idx);
        chk(b_almost_empty_n == (stored > XOFS), "R7 almost-empty level", b_almost_empty_n, stored > XOFS);
        chk(a_almost_full_n == ((DEPTH - prot) > YOFS), "R8 almost-full level", a_almost_full_n, (DEPTH - prot) > YOFS);
        chk(a_ready == (prot != DEPTH), "R12 write space ready", a_ready, prot != DEPTH);
        chk(b_ready == (stored > 0), "R4 read ready level", b_ready, stored > 0);
    endtask

    task automatic drain(input int exp, input string tag);
        int n;
        n = 0;
        idle(6);
        while (b_ready && n < 100) begin
            rd1();
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        // R9: reset values
        repeat (3) @(negedge clk);
        chk(a_ready == 0, "R9 a_ready in reset", a_ready, 0);
        chk(b_ready == 0, "R9 b_ready in reset", b_ready, 0);
        chk(b_almost_empty_n == 0, "R9 almost-empty in reset", b_almost_empty_n, 0);
        chk(a_almost_full_n == 1, "R9 almost-full in reset", a_almost_full_n, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(a_ready == 1, "R9 a_ready after release", a_ready, 1);

        // R5: ready latency after a write into empty
        wr1();
        chk(b_ready == 0, "R5 not ready after write edge", b_ready, 0);
        idle(1);
        chk(b_ready == 0, "R5 not ready after first edge", b_ready, 0);
        idle(1);
        chk(b_ready == 0, "R5 not ready after second edge", b_ready, 0);
        idle(1);
        chk(b_ready == 1, "R5 ready on third edge", b_ready, 1);

        // R1: disqualified writes dropped; R2: disqualified reads ignored
        step(P_NOEN, mkd(900), P_OFF, 0, 0);
        step(P_DIR0, mkd(901), P_OFF, 0, 0);
        step(P_OFF, mkd(902), P_OFF, 0, 0);
        wr1();
        wr1();
        step(P_OFF, '0, P_NOEN, 0, 0);
        step(P_OFF, '0, P_DIR0, 0, 0);
        step(P_OFF, '0, P_OFF, 0, 0);
        drain(3, "R1 only qualified writes stored");

        // R6: concurrent writes and reads
        for (int i = 0; i < 40; i++) begin
            step(P_GO, mkd(seq), (i >= 3 && i % 3 != 0) ? P_GO : P_OFF, 0, 0);
            seq++;
        end
        drain(written.size() - rd_idx, "R6 stream count");

        // R3: fill past capacity
        for (int i = 0; i < 20; i++) wr1();
        chk(written.size() - rd_idx == DEPTH, "R3 accepted count at full", written.size() - rd_idx, DEPTH);
        chk(a_ready == 0, "R3 a_ready low at full", a_ready, 0);
        settle_check();
        drain(DEPTH, "R3 drained count");

        // R4: reads on empty ignored
        for (int i = 0; i < 3; i++) rd1();
        chk(b_ready == 0, "R4 stays empty", b_ready, 0);
        wr1();
        drain(1, "R4 next word after empty reads");

        // R7, R8: flags at each fill level
        settle_check();
        for (int k = 1; k <= DEPTH; k++) begin
            wr1();
            settle_check();
        end
        drain(DEPTH, "R7 drain after level sweep");

        // R10, R11: mark and rewind
        for (int i = 0; i < 6; i++) wr1();
        idle(6);
        rd1();
        rd1();
        hold_rtm = 1;
        idle(1);
        chk(m_rt == 1, "R10 model entered mode", m_rt, 1);
        rd1();
        rd1();
        rd1();
        step(P_OFF, '0, P_OFF, 1, 1);
        chk(b_data == written[mark_idx], "R11 marked word shown", b_data, written[mark_idx]);
        rd1();
        step(P_OFF, '0, P_OFF, 1, 1);
        chk(b_data == written[mark_idx], "R11 second rewind", b_data, written[mark_idx]);
        rd1();
        hold_rtm = 0;
        idle(1);
        step(P_OFF, '0, P_OFF, 0, 1);
        chk(b_data == written[rd_idx], "R11 rewind ignored outside mode", b_data, written[rd_idx]);
        drain(written.size() - rd_idx, "R10 drain after exit");

        // R12: writes held back by the mark
        for (int i = 0; i < 8; i++) wr1();
        idle(6);
        rd1();
        rd1();
        rd1();
        hold_rtm = 1;
        idle(1);
        rd1();
        rd1();
        idle(30);
        for (int i = 0; i < 20; i++) wr1();
        chk(written.size() - mark_idx == DEPTH, "R12 span from mark at full", written.size() - mark_idx, DEPTH);
        chk(a_ready == 0, "R12 a_ready low", a_ready, 0);
        settle_check();
        step(P_OFF, '0, P_OFF, 1, 1);
        drain(DEPTH, "R12 marked data intact");
        hold_rtm = 0;
        idle(1);
        settle_check();
        chk(a_ready == 1, "R12 space released after exit", a_ready, 1);

        done = 1;
        finish_up();
    end
endmodule